// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status registers of a hot-plug capable downstream port. Software programs it through a small configuration bus that writes 16-bit registers with per-byte enables and reads any of the three registers back combinationally. The slot itself feeds it attention-button presses and insert or remove requests.

The block records slot events as sticky status bits and drives an interlock state that software toggles. It signals software in one of two ways. In message mode it sends a one-clock pulse that carries a configured 5-bit vector. In legacy mode it drives a registered interrupt level. Control writes complete at once, so every write to the control register reports a command-completed event in the same cycle.

Insert and remove requests pass through a four-state machine. HP_IDLE is the only state that accepts a request. From HP_IDLE the transition T_ACCEPT_INS leads to HP_INSERT and T_ACCEPT_REM leads to HP_REMOVE, both taken when the interlock is released. When the interlock is engaged, T_LOCKED leads to HP_REFUSE whatever the request is. Each of the three non-idle states lasts one cycle and goes back to HP_IDLE through T_DONE.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the control register reads 0x00F0. Its enables are cleared, and both indicator fields (power at bits 7:6, attention at bits 5:4) hold the off code 2'b11. The status register reads 0 except for presence state (bit 3), which takes the PRES_INIT parameter. Neither interrupt output is active.
- R2: The capability register (read select 0) reads SLOT_NUM at bits 31:19 and has bits 5:0 set. Those six bits mark button, power indicator, attention indicator, surprise removal, hot-plug capable and interlock present.
- R3: Status bits 0 (button pressed), 1 (presence changed) and 2 (command done) are write-one-to-clear through a status write (select 2) with byte enable 0 set. A status write with that byte enable clear changes nothing.
- R4: An event that sets a status bit in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R5: A control write (select 1) with any byte enable set raises the command-done event. Only the bytes whose enable is set are updated. The enables sit at bits 3:0: button, presence change, command done, and master interrupt enable at bit 3.
- R6: Writing 1 to control bit 8 with byte enable 1 set toggles interlock status (status bit 4). Control bit 8 always reads 0.
- R7: A request accepted in HP_IDLE while the interlock is engaged produces a one-cycle hp_busy and leaves presence unchanged. Otherwise it produces a one-cycle hp_ack and, one cycle later, sets or clears presence state and raises the presence-changed event.
- R8: In message mode, msg_valid pulses for one cycle with msg_vector equal to msi_vector when an event finds its status bit clear and both its enable and the master enable are set. An event whose status bit is already set sends nothing.
- R9: In message mode, a control write that raises an event enable from 0 to 1 while that event's status bit is set sends a message, provided the master enable is set after the write.
- R10: In legacy mode, irq_level is the registered value of master enable AND the OR over events of (enable AND status), and no message is ever sent. In message mode irq_level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Write target: 1 control, 2 status |
| cfg_wdata | input | 16 | Write data |
| cfg_be | input | 2 | Byte enables |
| cfg_rd_sel | input | 2 | Read select: 0 capability, 1 control, 2 status |
| cfg_rdata | output | 32 | Read data |
| btn_press | input | 1 | Attention-button event pulse |
| hp_req_valid | input | 1 | Insert/remove request |
| hp_req_insert | input | 1 | 1 insert, 0 remove |
| hp_req_ready | output | 1 | Request machine is idle |
| hp_ack | output | 1 | Request accepted |
| hp_busy | output | 1 | Request refused, interlock engaged |
| msi_mode | input | 1 | 1 message mode, 0 legacy level mode |
| msi_vector | input | 5 | Vector carried by messages |
| msg_valid | output | 1 | One-cycle message pulse |
| msg_vector | output | 5 | Vector of the message |
| irq_level | output | 1 | Legacy interrupt level |

## Verification
The bench builds the block with SLOT_NUM 7, vector 19 and presence clear at reset. Because there are only four enable bits, the bench sweeps all sixteen enable patterns in both interrupt modes. Each pattern runs through the same sequence of events, clears, enable re-arming, interlock toggles and refused requests, so the expected interrupt outputs come straight from the enable bits.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    typedef enum logic [1:0] {
        HP_IDLE   = 2'd0,
        HP_INSERT = 2'd1,
        HP_REMOVE = 2'd2,
        HP_REFUSE = 2'd3
    } hp_state_e;

    localparam logic [1:0] SEL_CAP = 2'd0;
    localparam logic [1:0] SEL_CTL = 2'd1;
    localparam logic [1:0] SEL_STS = 2'd2;

    localparam int unsigned NUM_EV    = 3;   // button, presence change, command done
    localparam int unsigned REG_W     = 16;
    localparam int unsigned LANES     = REG_W / 8;
    localparam int unsigned CTL_HPIE  = 3;
    localparam int unsigned CTL_LOCK  = 8;
    localparam int unsigned STS_PRES  = 3;
    localparam int unsigned STS_LOCK  = 4;
    localparam logic [1:0]  IND_OFF   = 2'b11;
    localparam logic [15:0] CTL_STORE = 16'h00FF;
endpackage

// File: rtl/hp_req_fsm.sv
module hp_req_fsm
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_insert,
    input  logic lock_on,
    output logic ready,
    output logic do_insert,
    output logic do_remove,
    output logic busy
);
    hp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HP_IDLE: begin
                if (req_valid) begin
                    if (lock_on)         state_d = HP_REFUSE;   // T_LOCKED
                    else if (req_insert) state_d = HP_INSERT;   // T_ACCEPT_INS
                    else                 state_d = HP_REMOVE;   // T_ACCEPT_REM
                end
            end
            HP_INSERT, HP_REMOVE, HP_REFUSE: state_d = HP_IDLE; // T_DONE
            default: state_d = HP_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        do_insert = 1'b0;
        do_remove = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            HP_IDLE:   ready     = 1'b1;
            HP_INSERT: do_insert = 1'b1;
            HP_REMOVE: do_remove = 1'b1;
            HP_REFUSE: busy      = 1'b1;
            default:   ready     = 1'b0;
        endcase
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter bit PRES_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic [LANES-1:0]  be,
    input  logic              btn_ev,
    input  logic              do_insert,
    input  logic              do_remove,
    output logic [REG_W-1:0]  ctl_q,
    output logic [REG_W-1:0]  ctl_nx,
    output logic [REG_W-1:0]  sts_q,
    output logic [REG_W-1:0]  sts_nx,
    output logic [NUM_EV-1:0] ev,
    output logic              ctl_touch
);
    localparam logic [REG_W-1:0] CTL_RST = {8'h00, IND_OFF, IND_OFF, 4'h0};
    localparam logic [REG_W-1:0] STS_RST = REG_W'(PRES_INIT) << STS_PRES;

    logic [REG_W-1:0]  lane_mask;
    logic [REG_W-1:0]  ctl_wmask;
    logic              lock_flip;
    logic [NUM_EV-1:0] clr;
    logic [NUM_EV-1:0] ev_bits;
    logic              pres_nx;
    logic              lock_nx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be[g]}};
    end

    assign ctl_touch = wr_en && (wr_sel == SEL_CTL) && (|be);
    assign ctl_wmask = lane_mask & CTL_STORE;
    assign ctl_nx    = ctl_touch ? ((ctl_q & ~ctl_wmask) | (wdata & ctl_wmask)) : ctl_q;
    assign lock_flip = ctl_touch && be[CTL_LOCK/8] && wdata[CTL_LOCK];

    assign clr = (wr_en && (wr_sel == SEL_STS) && be[0]) ? wdata[NUM_EV-1:0] : '0;
    assign ev  = {ctl_touch, (do_insert | do_remove), btn_ev};

    assign ev_bits = (sts_q[NUM_EV-1:0] & ~clr) | ev;
    assign pres_nx = do_insert ? 1'b1 : (do_remove ? 1'b0 : sts_q[STS_PRES]);
    assign lock_nx = sts_q[STS_LOCK] ^ lock_flip;

    always_comb begin
        sts_nx                 = '0;
        sts_nx[NUM_EV-1:0]     = ev_bits;
        sts_nx[STS_PRES]       = pres_nx;
        sts_nx[STS_LOCK]       = lock_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            sts_q <= STS_RST;
        end else begin
            ctl_q <= ctl_nx;
            sts_q <= sts_nx;
        end
    end
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_slot_pkg::*;
#(
    parameter int unsigned VEC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_mode,
    input  logic [VEC_W-1:0]  msi_vector,
    input  logic [NUM_EV-1:0] en_q,
    input  logic [NUM_EV:0]   en_nx,
    input  logic              ctl_touch,
    input  logic [NUM_EV-1:0] sts_old,
    input  logic [NUM_EV-1:0] sts_new,
    input  logic [NUM_EV-1:0] ev,
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vector,
    output logic              irq_level
);
    logic              hpie;
    logic [NUM_EV-1:0] ev_en;
    logic [NUM_EV-1:0] fresh;
    logic [NUM_EV-1:0] rearm;
    logic              fire;
    logic              level;

    assign hpie  = en_nx[CTL_HPIE];
    assign ev_en = en_nx[NUM_EV-1:0];
    assign fresh = ev & ~sts_old & ev_en;
    assign rearm = ctl_touch ? (ev_en & ~en_q & sts_old) : '0;
    assign fire  = msi_mode && hpie && (|(fresh | rearm));
    assign level = !msi_mode && hpie && (|(ev_en & sts_new));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_vector <= '0;
            irq_level  <= 1'b0;
        end else begin
            msg_valid  <= fire;
            msg_vector <= fire ? msi_vector : msg_vector;
            irq_level  <= level;
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int unsigned SLOT_W    = 13,
    parameter logic [12:0] SLOT_NUM  = 13'd1,
    parameter int unsigned VEC_W     = 5,
    parameter bit          PRES_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_sel,
    input  logic [15:0]      cfg_wdata,
    input  logic [1:0]       cfg_be,
    input  logic [1:0]       cfg_rd_sel,
    output logic [31:0]      cfg_rdata,
    input  logic             btn_press,
    input  logic             hp_req_valid,
    input  logic             hp_req_insert,
    output logic             hp_req_ready,
    output logic             hp_ack,
    output logic             hp_busy,
    input  logic             msi_mode,
    input  logic [VEC_W-1:0] msi_vector,
    output logic             msg_valid,
    output logic [VEC_W-1:0] msg_vector,
    output logic             irq_level
);
    localparam int unsigned CAP_FLAGS = 6;
    localparam logic [31:0] CAP_VAL =
        (32'(SLOT_NUM[SLOT_W-1:0]) << (32 - SLOT_W)) | 32'((1 << CAP_FLAGS) - 1);

    logic [REG_W-1:0]  ctl_q, ctl_nx, sts_q, sts_nx;
    logic [NUM_EV-1:0] ev;
    logic              ctl_touch;
    logic              do_insert, do_remove;

    hp_req_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (hp_req_valid),
        .req_insert (hp_req_insert),
        .lock_on    (sts_q[STS_LOCK]),
        .ready      (hp_req_ready),
        .do_insert  (do_insert),
        .do_remove  (do_remove),
        .busy       (hp_busy)
    );

    assign hp_ack = do_insert | do_remove;

    hp_slot_regs #(.PRES_INIT(PRES_INIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_wr_sel),
        .wdata     (cfg_wdata),
        .be        (cfg_be),
        .btn_ev    (btn_press),
        .do_insert (do_insert),
        .do_remove (do_remove),
        .ctl_q     (ctl_q),
        .ctl_nx    (ctl_nx),
        .sts_q     (sts_q),
        .sts_nx    (sts_nx),
        .ev        (ev),
        .ctl_touch (ctl_touch)
    );

    hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
        .clk        (clk),
        .rst_n      (rst_n),
        .msi_mode   (msi_mode),
        .msi_vector (msi_vector),
        .en_q       (ctl_q[NUM_EV-1:0]),
        .en_nx      (ctl_nx[NUM_EV:0]),
        .ctl_touch  (ctl_touch),
        .sts_old    (sts_q[NUM_EV-1:0]),
        .sts_new    (sts_nx[NUM_EV-1:0]),
        .ev         (ev),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector),
        .irq_level  (irq_level)
    );

    always_comb begin
        unique case (cfg_rd_sel)
            SEL_CAP: cfg_rdata = CAP_VAL;
            SEL_CTL: cfg_rdata = {16'h0000, ctl_q};
            SEL_STS: cfg_rdata = {16'h0000, sts_q};
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       msi_mode,
    input logic       msg_valid,
    input logic       irq_level,
    input logic       hp_req_valid,
    input logic       hp_req_ready,
    input logic       hp_ack,
    input logic       hp_busy,
    input logic       cfg_wr_en,
    input logic [1:0] cfg_wr_sel,
    input logic [1:0] cfg_be,
    input logic [1:0] cfg_rd_sel,
    input logic       rd_bit8,
    input logic [4:0] sts
);
    AST_LEGACY_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(msi_mode)); // R10
    AST_MSG_MODE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_mode && $past(msi_mode)) |-> !irq_level); // R10
    AST_CMD_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_sel == 2'd1 && cfg_be != 2'b00) |=> sts[2]); // R5
    AST_LOCK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_sel == 2'd1) |-> !rd_bit8); // R6
    AST_ACK_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hp_ack && hp_busy)); // R7
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_req_valid && hp_req_ready) |=> (hp_ack || hp_busy)); // R7
    AST_BUSY_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        hp_busy |-> $past(sts[4])); // R7
    AST_BUSY_KEEPS_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        hp_busy |=> $stable(sts[3])); // R7
    AST_ACK_RAISES_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        hp_ack |=> sts[1]); // R7
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msi_mode     (msi_mode),
    .msg_valid    (msg_valid),
    .irq_level    (irq_level),
    .hp_req_valid (hp_req_valid),
    .hp_req_ready (hp_req_ready),
    .hp_ack       (hp_ack),
    .hp_busy      (hp_busy),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_sel   (cfg_wr_sel),
    .cfg_be       (cfg_be),
    .cfg_rd_sel   (cfg_rd_sel),
    .rd_bit8      (cfg_rdata[8]),
    .sts          (sts_q[4:0])
);

// File: tb/hp_slot_ctrl_bench.sv
`timescale 1ns/1ps
module hp_slot_ctrl_bench;
    localparam logic [12:0] SLOT = 13'd7;
    localparam logic [4:0]  VEC  = 5'd19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [1:0]  cfg_be = 2'b00;
    logic [1:0]  cfg_rd_sel = 2'd0;
    logic [31:0] cfg_rdata;
    logic        btn_press = 1'b0;
    logic        hp_req_valid = 1'b0;
    logic        hp_req_insert = 1'b0;
    logic        hp_req_ready, hp_ack, hp_busy;
    logic        msi_mode = 1'b0;
    logic [4:0]  msg_vector;
    logic        msg_valid, irq_level;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hp_slot_ctrl #(.SLOT_NUM(SLOT), .VEC_W(5), .PRES_INIT(1'b0)) u_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rd_sel(cfg_rd_sel),
        .cfg_rdata(cfg_rdata), .btn_press(btn_press), .hp_req_valid(hp_req_valid),
        .hp_req_insert(hp_req_insert), .hp_req_ready(hp_req_ready), .hp_ack(hp_ack),
        .hp_busy(hp_busy), .msi_mode(msi_mode), .msi_vector(VEC),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .irq_level(irq_level));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        cfg_rd_sel = sel;
        #1;
        v = cfg_rdata;
    endtask

    // one clock of stimulus; returns at the falling edge after the active edge
    task automatic op(input logic we, input logic [1:0] sel, input logic [15:0] d,
                      input logic [1:0] be, input logic btn);
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_sel = sel; cfg_wdata = d; cfg_be = be; btn_press = btn;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = 2'b00; btn_press = 1'b0;
    endtask

    task automatic req(input logic ins, output logic ack, output logic busy);
        @(negedge clk);
        hp_req_valid = 1'b1; hp_req_insert = ins;
        @(negedge clk);
        hp_req_valid = 1'b0;
        ack = hp_ack; busy = hp_busy;
        @(negedge clk);
    endtask

    task automatic chk_irq(input string req_tag, input logic exp_msg, input logic exp_irq);
        chk({req_tag, " msg_valid"}, 32'(msg_valid), 32'(exp_msg));
        if (exp_msg) chk({req_tag, " msg_vector"}, 32'(msg_vector), 32'(VEC));
        chk({req_tag, " irq_level"}, 32'(irq_level), 32'(exp_irq));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic ack, busy;
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 16; e++) begin
                logic b, p, c, h, mm, lg;
                logic [15:0] en;
                en = 16'(e);
                b = en[0]; p = en[1]; c = en[2]; h = en[3];
                mm = (m == 1); lg = !mm;
                msi_mode = mm;
                rst_n = 1'b0;
                repeat (2) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset values
                rd(2'd1, v); chk("R1 ctl reset", v, 32'h00F0);
                rd(2'd2, v); chk("R1 sts reset", v, 32'h0);
                chk("R1 msg reset", 32'(msg_valid), 0);
                chk("R1 irq reset", 32'(irq_level), 0);
                chk("R1 ready reset", 32'(hp_req_ready), 1);
                rd(2'd0, v); chk("R2 capability", v, (32'(SLOT) << 19) | 32'h3F);

                // R5/R8: enable write raises command done
                op(1'b1, 2'd1, 16'h00F0 | en, 2'b01, 1'b0);
                chk_irq("R8 cmd", mm & h & c, lg & h & c);
                rd(2'd2, v); chk("R5 cmd done", v, 32'h4);
                rd(2'd1, v); chk("R5 ctl write", v, 32'(16'h00F0 | en));

                // R8 button, then recurrence is silent
                op(1'b0, 2'd0, 16'h0, 2'b00, 1'b1);
                chk_irq("R8 btn", mm & h & b, lg & h & (b | c));
                op(1'b0, 2'd0, 16'h0, 2'b00, 1'b1);
                chk_irq("R8 btn again", 1'b0, lg & h & (b | c));

                // R7 insert
                req(1'b1, ack, busy);
                chk("R7 insert ack", 32'(ack), 1);
                chk("R7 insert busy", 32'(busy), 0);
                chk_irq("R8 pres", mm & h & p, lg & h & (b | c | p));
                rd(2'd2, v); chk("R7 pres set", v, 32'h0F);

                // R3 clear
                op(1'b1, 2'd2, 16'h0007, 2'b01, 1'b0);
                chk_irq("R3 cleared", 1'b0, 1'b0);
                rd(2'd2, v); chk("R3 w1c", v, 32'h08);

                // R9 re-arm enables while events pending
                op(1'b1, 2'd1, 16'h00F0, 2'b01, 1'b0);
                op(1'b0, 2'd0, 16'h0, 2'b00, 1'b1);
                chk_irq("R8 disabled", 1'b0, 1'b0);
                rd(2'd2, v); chk("R9 pending", v, 32'h0D);
                op(1'b1, 2'd1, 16'h00F0 | en, 2'b01, 1'b0);
                chk_irq("R9 rearm", mm & h & (b | c), lg & h & (b | c));

                // R6 interlock toggle with upper byte only
                op(1'b1, 2'd1, 16'h0100, 2'b10, 1'b0);
                chk_irq("R6 toggle", 1'b0, lg & h & (b | c));
                rd(2'd1, v); chk("R6 bit8 reads 0 / R5 lanes", v, 32'(16'h00F0 | en));
                rd(2'd2, v); chk("R6 lock on", v, 32'h1D);

                // R7 refused while locked
                req(1'b0, ack, busy);
                chk("R7 locked ack", 32'(ack), 0);
                chk("R7 locked busy", 32'(busy), 1);
                rd(2'd2, v); chk("R7 pres kept", v, 32'h1D);

                op(1'b1, 2'd1, 16'h0100, 2'b10, 1'b0);
                rd(2'd2, v); chk("R6 lock off", v, 32'h0D);
                req(1'b0, ack, busy);
                chk("R7 remove ack", 32'(ack), 1);
                chk_irq("R8 remove", mm & h & p, lg & h & (b | c | p));
                rd(2'd2, v); chk("R7 pres cleared", v, 32'h07);

                // R3 lane enable required, R4 event beats clear
                op(1'b1, 2'd2, 16'h0007, 2'b00, 1'b0);
                rd(2'd2, v); chk("R3 no lane", v, 32'h07);
                op(1'b1, 2'd2, 16'h0001, 2'b01, 1'b1);
                rd(2'd2, v); chk("R4 event wins", v, 32'h07);
                op(1'b1, 2'd2, 16'h0001, 2'b01, 1'b0);
                rd(2'd2, v); chk("R3 btn clear", v, 32'h06);
                chk("R10 legacy level", 32'(irq_level), 32'(lg & h & (c | p)));
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule